// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. An external level is brought into the clock domain and cleaned by a run-length glitch filter. An edge detector then turns the cleaned level into one-cycle edge pulses. The channel picks one of three event sources: its own filtered input, the filtered edges of the adjacent channel, or an internal trigger pulse. A power-of-two prescaler thins the chosen events. When an event survives the prescaler, the channel latches the value of the free-running counter.

Software reads the 16-bit captured value over an 8-bit bus, upper byte first. The upper-byte read arms a hold, and the lower-byte read releases it. A capture that arrives while the hold is armed is parked in a shadow register. It is moved into the readable register at the clock edge where the lower byte is read, so the two bytes always belong to one capture. The channel also provides a sticky capture flag and an any-edge pulse taken from its own filtered input, meant for a slave-mode controller.

Top module: `tmr_capture_chan`

## Requirements
- R1: After reset, cap_val is 0, cap_flag is 0 and edge_any is 0.
- R2: The input passes through a 2-flop synchronizer. The filtered level follows the synchronized level only after max(cfg_filt,1) consecutive clocks in which the two differ, so a change of raw_in shows up on edge_any after 2+max(cfg_filt,1) rising clock edges. Any shorter excursion is dropped.
- R3: edge_any is high for one cycle after each rising or falling change of the filtered own input, whatever the polarity setting.
- R4: cfg_src selects the capture event source. 2'b01 is the own filtered input, 2'b10 is the adjacent channel (nbr_rise/nbr_fall) and 2'b11 is trig_in. 2'b00 produces no captures, software ones included.
- R5: cfg_pol=0 takes rising edges and cfg_pol=1 takes falling edges, for both the own and the adjacent source.
- R6: With cfg_psc=k, one capture is taken every 2^k source events (1, 2, 4, 8).
- R7: The prescaler count returns to zero while cfg_en is 0 and on any clock with cfg_psc_wr high.
- R8: With cfg_en=0, neither hardware events nor sw_capture change cap_val or cap_flag.
- R9: A sw_capture pulse, with cfg_en=1 and a nonzero source, captures at once and bypasses the prescaler.
- R10: A capture samples cnt_val at the clock edge where the event is present. With no read hold, the value is visible on cap_val right after that edge. For the own input with filter 0, this is the edge 3 clocks after raw_in was sampled.
- R11: While rd_hi is high, rd_data carries cap_val[15:8], and rd_lo shows cap_val[7:0]. A clock with rd_hi arms the hold and a clock with rd_lo releases it. While the hold is armed, cap_val stays unchanged, and the newest held capture is loaded at the rd_lo edge.
- R12: cap_flag is set by every capture, held or not, and cleared by flag_clr. A capture in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | External input of this channel |
| nbr_rise | input | 1 | Filtered rising-edge pulse from the adjacent channel |
| nbr_fall | input | 1 | Filtered falling-edge pulse from the adjacent channel |
| trig_in | input | 1 | Internal trigger pulse |
| cnt_val | input | 16 | Free-running counter value |
| cfg_filt | input | 4 | Filter run length, 0 = no filtering |
| cfg_pol | input | 1 | Edge polarity, 0 rising, 1 falling |
| cfg_src | input | 2 | Capture source select |
| cfg_psc | input | 2 | Prescaler exponent |
| cfg_psc_wr | input | 1 | Pulse: prescaler field written |
| cfg_en | input | 1 | Capture enable |
| sw_capture | input | 1 | Software forced capture pulse |
| rd_hi | input | 1 | Upper-byte read strobe |
| rd_lo | input | 1 | Lower-byte read strobe |
| flag_clr | input | 1 | Clear capture flag |
| rd_data | output | 8 | Byte read data |
| cap_val | output | 16 | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| edge_any | output | 1 | Any-edge pulse of own filtered input |

## Verification
The own-input path has a fixed latency. edge_any rises 2+max(cfg_filt,1) edges after raw_in is sampled, and the capture lands one edge later. The bench therefore measures these edge counts directly and works out expected counter values from the number of edges elapsed. Captures from the adjacent channel, the trigger and software are all due at the first edge that samples the pulse, and the flag and value are read half a cycle after that edge. A behavioural reference model steps at every rising edge and is compared with cap_val, cap_flag, edge_any and rd_data at every falling edge, where all results of the preceding edge have settled.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'b00,
      SRC_OWN  = 2'b01,
      SRC_NBR  = 2'b10,
      SRC_TRG  = 2'b11
   } src_e;
endpackage

// File: rtl/tcc_filter.sv
module tcc_filter #(
   parameter int SYNC_N = 2,
   parameter int FLT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic [FLT_W-1:0] run_len,
   output logic             filt_o
);
   logic [SYNC_N-1:0] sync_q;
   logic [FLT_W-1:0]  run_q;
   logic [FLT_W:0]    run_nxt;
   logic [FLT_W:0]    need;
   logic              samp;

   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("tcc_filter: SYNC_N must be at least 2");
      end
      for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= raw;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
         end
      end
   endgenerate

   assign samp    = sync_q[SYNC_N-1];
   assign run_nxt = {1'b0, run_q} + 1'b1;
   assign need    = (run_len == '0) ? {{FLT_W{1'b0}}, 1'b1} : {1'b0, run_len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_o <= 1'b0;
         run_q  <= '0;
      end else if (samp != filt_o) begin
         if (run_nxt >= need) begin
            filt_o <= samp;
            run_q  <= '0;
         end else begin
            run_q  <= run_nxt[FLT_W-1:0];
         end
      end else begin
         run_q <= '0;
      end
   end

   assert_filt_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_o != $past(filt_o)) |-> (filt_o == $past(samp)));
endmodule

// File: rtl/tcc_edge.sv
module tcc_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic pol,
   output logic pick,
   output logic any
);
   logic lvl_d;
   logic up;
   logic dn;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;

   assign up   = lvl & ~lvl_d;
   assign dn   = ~lvl & lvl_d;
   assign pick = pol ? dn : up;
   assign any  = up | dn;
endmodule

// File: rtl/tcc_prescaler.sv
module tcc_prescaler #(
   parameter int PSC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev,
   input  logic [PSC_W-1:0] ratio,
   input  logic             clr,
   output logic             fire
);
   localparam int CNT_W = (1 << PSC_W) - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   generate
      if (PSC_W < 1 || PSC_W > 3) begin : g_bad_psc
         $error("tcc_prescaler: PSC_W must be 1 to 3");
      end
   endgenerate

   always_comb begin
      lim = '0;
      for (int i = 0; i < CNT_W; i++)
         if (i < int'(ratio)) lim[i] = 1'b1;
   end

   assign fire = ev && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (ev)    cnt_q <= fire ? '0 : cnt_q + 1'b1;
   end

   assert_psc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
endmodule

// File: rtl/tcc_capreg.sv
module tcc_capreg #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             rd_hi,
   input  logic             rd_lo,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cap_val,
   output logic [BUS_W-1:0] rd_data,
   output logic             flag
);
   logic [CNT_W-1:0] shadow_q;
   logic             pend_q;
   logic             hold_q;
   logic             blocked;

   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("tcc_capreg: CNT_W must be twice BUS_W");
      end
   endgenerate

   assign blocked = rd_hi | (hold_q & ~rd_lo);
   assign rd_data = rd_hi ? cap_val[CNT_W-1:BUS_W] :
                    rd_lo ? cap_val[BUS_W-1:0]     : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val  <= '0;
         shadow_q <= '0;
         pend_q   <= 1'b0;
      end else if (cap) begin
         if (blocked) begin
            shadow_q <= cnt_val;
            pend_q   <= 1'b1;
         end else begin
            cap_val  <= cnt_val;
            pend_q   <= 1'b0;
         end
      end else if (pend_q && !blocked) begin
         cap_val <= shadow_q;
         pend_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_q <= 1'b0;
      else if (rd_hi) hold_q <= 1'b1;
      else if (rd_lo) hold_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (cap)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_hi) || ($past(hold_q) && !$past(rd_lo))) |-> $stable(cap_val));
   assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag) && !$past(flag_clr)) |-> flag);
   assert_cap_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cap) && !$past(blocked)) |-> (cap_val == $past(cnt_val)));
endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan #(
   parameter int SYNC_N = 2,
   parameter int FLT_W  = 4,
   parameter int PSC_W  = 2,
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_in,
   input  logic             nbr_rise,
   input  logic             nbr_fall,
   input  logic             trig_in,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [FLT_W-1:0] cfg_filt,
   input  logic             cfg_pol,
   input  logic [1:0]       cfg_src,
   input  logic [PSC_W-1:0] cfg_psc,
   input  logic             cfg_psc_wr,
   input  logic             cfg_en,
   input  logic             sw_capture,
   input  logic             rd_hi,
   input  logic             rd_lo,
   input  logic             flag_clr,
   output logic [BUS_W-1:0] rd_data,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_flag,
   output logic             edge_any
);
   import tcc_pkg::*;

   logic filt_lvl;
   logic own_pick;
   logic nbr_pick;
   logic src_ev;
   logic src_on;
   logic psc_fire;
   logic cap_evt;
   src_e src_sel;

   tcc_filter #(.SYNC_N(SYNC_N), .FLT_W(FLT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_in), .run_len(cfg_filt), .filt_o(filt_lvl)
   );

   tcc_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(filt_lvl), .pol(cfg_pol),
      .pick(own_pick), .any(edge_any)
   );

   assign nbr_pick = cfg_pol ? nbr_fall : nbr_rise;
   assign src_sel  = src_e'(cfg_src);

   always_comb begin
      case (src_sel)
         SRC_OWN: src_ev = own_pick;
         SRC_NBR: src_ev = nbr_pick;
         SRC_TRG: src_ev = trig_in;
         default: src_ev = 1'b0;
      endcase
   end

   assign src_on = (src_sel != SRC_NONE);

   tcc_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .ev(src_ev & cfg_en), .ratio(cfg_psc),
      .clr(~cfg_en | cfg_psc_wr), .fire(psc_fire)
   );

   assign cap_evt = (psc_fire | sw_capture) & cfg_en & src_on;

   tcc_capreg #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .cap(cap_evt), .cnt_val(cnt_val),
      .rd_hi(rd_hi), .rd_lo(rd_lo), .flag_clr(flag_clr),
      .cap_val(cap_val), .rd_data(rd_data), .flag(cap_flag)
   );

   assert_flag_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_flag) |-> $past(cfg_en));
endmodule

// File: tb/tmr_capture_chan_tb.sv
module tmr_capture_chan_tb_top;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        raw = 1'b0, nbr_rise = 1'b0, nbr_fall = 1'b0, trg = 1'b0;
   logic [15:0] cnt = 16'd0;
   logic [3:0]  flen = 4'd0;
   logic        pol = 1'b0, psc_wr = 1'b0, en = 1'b0, sw = 1'b0;
   logic [1:0]  src = 2'd0, psc = 2'd0;
   logic        rd_hi = 1'b0, rd_lo = 1'b0, fclr = 1'b0;
   logic [7:0]  rd_data;
   logic [15:0] cap_val;
   logic        cap_flag, edge_any;

   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   tmr_capture_chan dut_i (
      .clk(clk), .rst_n(rst_n), .raw_in(raw), .nbr_rise(nbr_rise), .nbr_fall(nbr_fall),
      .trig_in(trg), .cnt_val(cnt), .cfg_filt(flen), .cfg_pol(pol), .cfg_src(src),
      .cfg_psc(psc), .cfg_psc_wr(psc_wr), .cfg_en(en), .sw_capture(sw),
      .rd_hi(rd_hi), .rd_lo(rd_lo), .flag_clr(fclr),
      .rd_data(rd_data), .cap_val(cap_val), .cap_flag(cap_flag), .edge_any(edge_any)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cnt <= cnt + 16'd1;

   // behavioural reference model
   bit          sq[$] = '{1'b0, 1'b0};
   bit          m_filt = 0, m_filtd = 0, m_pend = 0, m_flag = 0, m_hold = 0;
   int          m_run = 0, m_pc = 0;
   logic [15:0] m_cap = 0, m_sh = 0;
   bit          e_sel, e_fire, e_cap, e_blk, e_s2;
   int          e_need;

   always @(posedge clk) begin
      if (!rst_n) begin
         sq = '{1'b0, 1'b0}; m_filt = 0; m_filtd = 0; m_run = 0; m_pc = 0;
         m_cap = 0; m_sh = 0; m_pend = 0; m_flag = 0; m_hold = 0;
      end else begin
         case (src)
            2'd1: e_sel = pol ? (!m_filt && m_filtd) : (m_filt && !m_filtd);
            2'd2: e_sel = pol ? nbr_fall : nbr_rise;
            2'd3: e_sel = trg;
            default: e_sel = 0;
         endcase
         e_sel  = e_sel && en;
         e_fire = e_sel && (m_pc == (1 << psc) - 1);
         if (!en || psc_wr) m_pc = 0;
         else if (e_sel)    m_pc = e_fire ? 0 : m_pc + 1;
         e_cap = (e_fire || sw) && en && (src != 2'd0);
         e_blk = rd_hi || (m_hold && !rd_lo);
         if (e_cap) begin
            m_flag = 1;
            if (e_blk) begin m_sh = cnt; m_pend = 1; end
            else begin m_cap = cnt; m_pend = 0; end
         end else if (m_pend && !e_blk) begin
            m_cap = m_sh; m_pend = 0;
         end
         if (fclr && !e_cap) m_flag = 0;
         if (rd_hi) m_hold = 1; else if (rd_lo) m_hold = 0;
         m_filtd = m_filt;
         e_s2 = sq[1];
         e_need = (flen == 0) ? 1 : int'(flen);
         if (e_s2 != m_filt) begin
            m_run++;
            if (m_run >= e_need) begin m_filt = e_s2; m_run = 0; end
         end else m_run = 0;
         sq.push_front(raw);
         void'(sq.pop_back());
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cap_val, m_cap, "R10 model cap_val");
         chk(cap_flag, m_flag, "R12 model cap_flag");
         chk(edge_any, m_filt ^ m_filtd, "R3 model edge_any");
         chk(rd_data, rd_hi ? m_cap[15:8] : rd_lo ? m_cap[7:0] : 8'd0, "R11 model rd_data");
      end
   end

   task automatic cyc(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic measure(output int n);
      n = 0;
      while (n < 20) begin
         @(posedge clk); n++;
         @(negedge clk); #1;
         if (edge_any) break;
      end
   endtask

   task automatic clear_flag();
      fclr = 1; cyc(1); fclr = 0;
   endtask

   task automatic trig_pulse();
      trg = 1; cyc(1); trg = 0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1; nchk++; nerr++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int n;
      bit seen;
      logic [15:0] c0, old;
      cyc(4); rst_n = 1; cyc(1);
      chk(cap_val, 0, "R1 reset cap_val");
      chk(cap_flag, 0, "R1 reset cap_flag");
      chk(edge_any, 0, "R1 reset edge_any");

      en = 1; src = 2'd1; pol = 0; flen = 0; psc = 0; psc_wr = 1; cyc(1); psc_wr = 0; cyc(2);
      // R2 latency, no filtering; R10 capture value
      c0 = cnt; raw = 1; measure(n);
      chk(n, 3, "R2 latency filter 0");
      cyc(1);
      chk(cap_val, 16'(c0 + 16'd3), "R10 own rising capture");
      clear_flag();
      chk(cap_flag, 0, "R12 flag cleared");
      raw = 0; cyc(6);
      chk(cap_flag, 0, "R5 falling ignored with rising polarity");

      // R2 latency with run length 3
      flen = 4'd3; c0 = cnt; raw = 1; measure(n);
      chk(n, 5, "R2 latency filter 3");
      cyc(1);
      chk(cap_val, 16'(c0 + 16'd5), "R10 capture with filter 3");
      // R2 short glitch dropped
      raw = 0; cyc(2); raw = 1; seen = 0;
      repeat (10) begin cyc(1); if (edge_any) seen = 1; end
      chk(seen, 0, "R2 glitch of 2 samples dropped");

      // R5 falling polarity on own input
      flen = 0; pol = 1; clear_flag();
      c0 = cnt; raw = 0; cyc(5);
      chk(cap_flag, 1, "R5 falling edge captured");
      chk(cap_val, 16'(c0 + 16'd3), "R5 falling capture value");

      // R4 adjacent channel source
      src = 2'd2; pol = 0; clear_flag();
      c0 = cnt; nbr_rise = 1; cyc(1); nbr_rise = 0;
      chk(cap_val, c0, "R4 adjacent source capture");
      chk(cap_flag, 1, "R4 adjacent source flag");
      clear_flag();
      nbr_fall = 1; cyc(1); nbr_fall = 0; cyc(1);
      chk(cap_flag, 0, "R5 adjacent falling ignored");

      // R4 trigger source
      src = 2'd3; clear_flag();
      c0 = cnt; trig_pulse();
      chk(cap_val, c0, "R4 trigger source capture");
      chk(cap_flag, 1, "R4 trigger source flag");

      // R4 source none
      src = 2'd0; clear_flag();
      trig_pulse(); sw = 1; cyc(1); sw = 0; raw = 1; cyc(6);
      chk(cap_flag, 0, "R4 no source no capture");

      // R6 divide by 4
      src = 2'd3; psc = 2'd2; psc_wr = 1; fclr = 1; cyc(1); psc_wr = 0; fclr = 0;
      repeat (3) begin trig_pulse(); cyc(1); end
      chk(cap_flag, 0, "R6 three events below ratio 4");
      trig_pulse();
      chk(cap_flag, 1, "R6 fourth event captures");

      // R7 prescaler write clears count
      clear_flag();
      repeat (2) trig_pulse();
      psc_wr = 1; cyc(1); psc_wr = 0;
      repeat (3) trig_pulse();
      chk(cap_flag, 0, "R7 count cleared by prescaler write");
      trig_pulse();
      chk(cap_flag, 1, "R7 capture after four fresh events");
      // R7 enable low clears count
      clear_flag();
      repeat (2) trig_pulse();
      en = 0; cyc(1); en = 1;
      repeat (3) trig_pulse();
      chk(cap_flag, 0, "R7 count cleared by disable");
      trig_pulse();
      chk(cap_flag, 1, "R7 capture after re-enable");

      // R8 disable blocks captures
      psc = 0; psc_wr = 1; fclr = 1; en = 0; cyc(1); psc_wr = 0; fclr = 0;
      old = cap_val;
      trig_pulse(); sw = 1; cyc(1); sw = 0; cyc(1);
      chk(cap_flag, 0, "R8 no flag while disabled");
      chk(cap_val, old, "R8 value unchanged while disabled");
      en = 1;

      // R9 software capture bypasses prescaler
      psc = 2'd3; psc_wr = 1; fclr = 1; cyc(1); psc_wr = 0; fclr = 0;
      c0 = cnt; sw = 1; cyc(1); sw = 0;
      chk(cap_flag, 1, "R9 software capture flag");
      chk(cap_val, c0, "R9 software capture value");

      // R11 two-byte read interlock
      psc = 0; psc_wr = 1; fclr = 1; cyc(1); psc_wr = 0; fclr = 0;
      old = cap_val;
      rd_hi = 1; #1;
      chk(rd_data, old[15:8], "R11 upper byte");
      cyc(1); rd_hi = 0;
      c0 = cnt; trig_pulse();
      chk(cap_val, old, "R11 capture held during read");
      chk(cap_flag, 1, "R12 flag set by held capture");
      cyc(2);
      chk(cap_val, old, "R11 still held");
      rd_lo = 1; #1;
      chk(rd_data, old[7:0], "R11 lower byte matches held value");
      cyc(1); rd_lo = 0;
      chk(cap_val, c0, "R11 held capture transferred at lower read");

      // R12 set wins over clear
      fclr = 1; trg = 1; cyc(1); fclr = 0; trg = 0;
      chk(cap_flag, 1, "R12 set wins over clear");
      clear_flag();
      chk(cap_flag, 0, "R12 clear alone");

      cyc(2);
      done = 1;
      summary();
      $finish;
   end
endmodule